// File: doc/BRIEF.md
# UBI Chaining Sequencer

This block drives the chaining mode that turns a 512-bit tweakable block cipher into a compression function for input of any length. A caller first seeds the 512-bit chaining value, then streams typed argument segments (key, configuration, personalization, public key, key identifier, nonce, message, output) as 64-byte blocks over a valid/ready handshake. Each block comes with a byte count, a last flag and the 6-bit type code of its segment.

For every accepted block the sequencer zero-pads the data and builds a 128-bit tweak. The tweak holds the running byte position within the segment, the type code and first/final flags. It then presents the chaining value as the key, the padded block as the plaintext and the tweak on a request/done cipher port. When the cipher reports completion, the new chaining value is the cipher output XOR the padded block. Because the type and position enter every tweak, identical data fed under two different argument types yields different chaining values.

Arguments must arrive in strictly increasing type order. A segment that breaks the order is consumed from the input without any cipher call, and a sticky error flag is raised.

Top module: `ubi_chain_top`

## Requirements
- R1: After reset the chaining value is zero, `orderErr` is low, `cipValid` is low and `blkReady` is high.
- R2: A `hashStart` pulse while idle loads `initChain` into the chaining value on the next edge. It also clears `orderErr`, the segment state and the type history.
- R3: `blkReady` is high only while no cipher request is pending. A block is taken on an edge where `blkValid` and `blkReady` are both high. The next cycle `cipValid` rises and stays high, with stable key, text and tweak, until the edge where `cipDone` is high; after that edge `cipValid` is low.
- R4: The cipher key is the chaining value held at the time the block was taken.
- R5: On the edge where `cipDone` is high, the chaining value becomes `cipResult` XOR the padded block. At no other time except `hashStart` does it change.
- R6: Tweak bits 95:0 hold the number of bytes of the current segment taken so far, including the current block. A segment starts counting from zero.
- R7: Tweak bits 125:120 carry the segment type code and bits 119:96 are zero. The type codes in use are key 0, configuration 4, personalization 8, public key 12, key identifier 16, nonce 20, message 48 and output 63. The same data under two types gives two different chaining values.
- R8: Tweak bit 126 is set only on the first block of a segment and bit 127 only on the block flagged last.
- R9: Byte i of a block sits in bits 8i+7:8i. Bytes at or above the byte count are replaced by zero in the plaintext.
- R10: A segment of one block with a byte count of zero is processed as an all-zero block with both flags set and position zero.
- R11: The first segment after `hashStart` may have any type. Each later segment must have a type strictly greater than the last accepted segment's type. Otherwise `orderErr` is set and stays set until `hashStart`, and every block of that segment is taken without a cipher request and without changing the chaining value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| hashStart | input | 1 | Seed the chaining value and clear ordering state |
| initChain | input | 512 | Seed value loaded by `hashStart` |
| blkValid | input | 1 | Input block present |
| blkReady | output | 1 | Block can be taken this cycle |
| blkData | input | 512 | Block bytes, byte i in bits 8i+7:8i |
| blkBytes | input | 7 | Number of valid bytes, 0 to 64 |
| blkType | input | 6 | Type code of the segment |
| blkLast | input | 1 | Last block of the segment |
| cipValid | output | 1 | Cipher request pending |
| cipKey | output | 512 | Key to the cipher (chaining value) |
| cipText | output | 512 | Padded plaintext block |
| cipTweak | output | 128 | Tweak for this block |
| cipDone | input | 1 | Cipher result valid |
| cipResult | input | 512 | Cipher output |
| chainOut | output | 512 | Current chaining value |
| orderErr | output | 1 | Sticky type-order violation flag |

## Verification
The assertions rely on the environment. Held blocks are assumed to keep their contents while `blkValid` waits. Every block not flagged last is assumed to carry exactly 64 bytes. `cipDone` is assumed to pulse only while `cipValid` is high, and `hashStart` is assumed to pulse only while no cipher request is pending. The stimulus tasks drive one block at a time and fill every non-final block completely. They assert `hashStart` only between blocks, and the stub cipher answers exactly once per request after a chosen delay, so the inputs always stay inside those assumptions.

// File: rtl/ubi_chain_pkg.sv
package ubi_chain_pkg;
  // tweak layout (position, reserved gap, type, flags)
  localparam int TWK_W        = 128;
  localparam int POS_W        = 96;
  localparam int TYPE_W       = 6;
  localparam int TYPE_LSB     = 120;
  localparam int FIRST_BIT    = 126;
  localparam int FINAL_BIT    = 127;
  localparam int GAP_W        = TYPE_LSB - POS_W;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ubi_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic init;      // load seed, clear type history
    logic capture;   // latch padded block and tweak
    logic segStart;  // captured block opens a segment
    logic finalBlk;  // captured block closes a segment
    logic update;    // fold cipher output into chain
  } ubi_strobe_t;
endpackage

// File: rtl/ubi_chain_dp.sv
module ubi_chain_dp
  import ubi_chain_pkg::*;
#(
  parameter  int BLK_BYTES = 64,
  localparam int BLK_BITS  = 8 * BLK_BYTES,
  localparam int CNT_BITS  = $clog2(BLK_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ubi_strobe_t         strb,
  input  logic [BLK_BITS-1:0] initChain,
  input  logic [BLK_BITS-1:0] blkData,
  input  logic [CNT_BITS-1:0] blkBytes,
  input  logic [TYPE_W-1:0]   blkType,
  input  logic [BLK_BITS-1:0] cipResult,
  output logic                typeOk,
  output logic [BLK_BITS-1:0] chainOut,
  output logic [BLK_BITS-1:0] cipText,
  output logic [TWK_W-1:0]    cipTweak
);
  logic [BLK_BITS-1:0] chainQ;
  logic [BLK_BITS-1:0] textQ;
  logic [TWK_W-1:0]    tweakQ;
  logic [POS_W-1:0]    posQ;
  logic [TYPE_W-1:0]   lastTypeQ;
  logic                haveTypeQ;

  logic [BLK_BITS-1:0] padded;
  logic [POS_W-1:0]    posNext;
  logic [TWK_W-1:0]    tweakNext;

  // zero every byte lane at or above the byte count
  for (genvar i = 0; i < BLK_BYTES; i++) begin : g_pad
    assign padded[8*i +: 8] = (CNT_BITS'(i) < blkBytes) ? blkData[8*i +: 8] : 8'h00;
  end

  always_comb begin
    posNext   = (strb.segStart ? '0 : posQ) + POS_W'(blkBytes);
    tweakNext = '0;
    tweakNext[POS_W-1:0]                = posNext;
    tweakNext[TYPE_LSB +: TYPE_W]       = blkType;
    tweakNext[FIRST_BIT]                = strb.segStart;
    tweakNext[FINAL_BIT]                = strb.finalBlk;
  end

  assign typeOk = !haveTypeQ || (blkType > lastTypeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ    <= '0;
      textQ     <= '0;
      tweakQ    <= '0;
      posQ      <= '0;
      lastTypeQ <= '0;
      haveTypeQ <= 1'b0;
    end else begin
      if (strb.init) begin
        chainQ    <= initChain;
        haveTypeQ <= 1'b0;
        posQ      <= '0;
      end else if (strb.update) begin
        chainQ <= cipResult ^ textQ;
      end
      if (strb.capture) begin
        textQ  <= padded;
        tweakQ <= tweakNext;
        posQ   <= posNext;
        if (strb.segStart) begin
          lastTypeQ <= blkType;
          haveTypeQ <= 1'b1;
        end
      end
    end
  end

  assign chainOut = chainQ;
  assign cipText  = textQ;
  assign cipTweak = tweakQ;
endmodule

// File: rtl/ubi_chain_ctrl.sv
module ubi_chain_ctrl
  import ubi_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hashStart,
  input  logic        blkValid,
  input  logic        blkLast,
  input  logic        typeOk,
  input  logic        cipDone,
  output logic        blkReady,
  output logic        cipValid,
  output logic        orderErr,
  output ubi_strobe_t strb
);
  ubi_state_e stateQ;
  logic       inSegQ;
  logic       dropQ;
  logic       errQ;

  logic accept;
  logic takeBlk;
  logic badOpen;

  always_comb begin
    blkReady = (stateQ == ST_IDLE) && !hashStart;
    accept   = blkValid && blkReady;
    badOpen  = accept && !inSegQ && !typeOk;
    takeBlk  = accept && (inSegQ ? !dropQ : typeOk);

    strb          = '0;
    strb.init     = hashStart && (stateQ == ST_IDLE);
    strb.capture  = takeBlk;
    strb.segStart = takeBlk && !inSegQ;
    strb.finalBlk = blkLast;
    strb.update   = (stateQ == ST_WAIT) && cipDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      inSegQ <= 1'b0;
      dropQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (strb.init) begin
            inSegQ <= 1'b0;
            dropQ  <= 1'b0;
            errQ   <= 1'b0;
          end else if (accept) begin
            inSegQ <= !blkLast;
            if (badOpen) begin
              errQ  <= 1'b1;
              dropQ <= !blkLast;
            end else if (blkLast) begin
              dropQ <= 1'b0;
            end
            if (takeBlk) stateQ <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cipDone) stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign cipValid = (stateQ == ST_WAIT);
  assign orderErr = errQ;
endmodule

// File: rtl/ubi_chain_top.sv
module ubi_chain_top
  import ubi_chain_pkg::*;
#(
  parameter  int BLK_BYTES = 64,
  localparam int BLK_BITS  = 8 * BLK_BYTES,
  localparam int CNT_BITS  = $clog2(BLK_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hashStart,
  input  logic [BLK_BITS-1:0] initChain,
  input  logic                blkValid,
  output logic                blkReady,
  input  logic [BLK_BITS-1:0] blkData,
  input  logic [CNT_BITS-1:0] blkBytes,
  input  logic [TYPE_W-1:0]   blkType,
  input  logic                blkLast,
  output logic                cipValid,
  output logic [BLK_BITS-1:0] cipKey,
  output logic [BLK_BITS-1:0] cipText,
  output logic [TWK_W-1:0]    cipTweak,
  input  logic                cipDone,
  input  logic [BLK_BITS-1:0] cipResult,
  output logic [BLK_BITS-1:0] chainOut,
  output logic                orderErr
);
  ubi_strobe_t strb;
  logic        typeOk;

  ubi_chain_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hashStart (hashStart),
    .blkValid  (blkValid),
    .blkLast   (blkLast),
    .typeOk    (typeOk),
    .cipDone   (cipDone),
    .blkReady  (blkReady),
    .cipValid  (cipValid),
    .orderErr  (orderErr),
    .strb      (strb)
  );

  ubi_chain_dp #(.BLK_BYTES(BLK_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .initChain (initChain),
    .blkData   (blkData),
    .blkBytes  (blkBytes),
    .blkType   (blkType),
    .cipResult (cipResult),
    .typeOk    (typeOk),
    .chainOut  (chainOut),
    .cipText   (cipText),
    .cipTweak  (cipTweak)
  );

  // the chaining value is the cipher key
  assign cipKey = chainOut;
endmodule

// File: rtl/ubi_chain_chk.sv
module ubi_chain_chk
  import ubi_chain_pkg::*;
#(
  parameter  int BLK_BYTES = 64,
  localparam int BLK_BITS  = 8 * BLK_BYTES
) (
  input logic                clk,
  input logic                rstN,
  input logic                hashStart,
  input logic [BLK_BITS-1:0] initChain,
  input logic                blkReady,
  input logic                cipValid,
  input logic [BLK_BITS-1:0] cipKey,
  input logic [BLK_BITS-1:0] cipText,
  input logic [TWK_W-1:0]    cipTweak,
  input logic                cipDone,
  input logic [BLK_BITS-1:0] chainOut,
  input logic                orderErr
);
  // R3: no new block while a request is pending
  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    cipValid |-> !blkReady);

  // R3: request held steady until the cipher answers
  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (cipValid && !cipDone) |=> (cipValid && $stable(cipText) && $stable(cipTweak) && $stable(cipKey)));

  // R5: chain changes only on cipher completion or seeding
  a_r5_chain_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!cipDone && !hashStart) |=> $stable(chainOut));

  // R2: seeding while idle loads the seed and clears the flag
  a_r2_seed_loads: assert property (@(posedge clk) disable iff (!rstN)
    (hashStart && !cipValid) |=> (chainOut == $past(initChain) && !orderErr));

  // R11: order error stays until the next seed
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (orderErr && !hashStart) |=> orderErr);

  // R10: zero position only for an empty, all-zero block
  a_r10_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cipValid && cipTweak[POS_W-1:0] == '0) |-> (cipText == '0 && cipTweak[FIRST_BIT] && cipTweak[FINAL_BIT]));

  // R6: a continuation block follows at least one full block
  a_r6_cont_pos: assert property (@(posedge clk) disable iff (!rstN)
    (cipValid && !cipTweak[FIRST_BIT]) |-> (cipTweak[POS_W-1:0] >= POS_W'(BLK_BYTES)));
endmodule

bind ubi_chain_top ubi_chain_chk #(.BLK_BYTES(BLK_BYTES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hashStart (hashStart),
  .initChain (initChain),
  .blkReady  (blkReady),
  .cipValid  (cipValid),
  .cipKey    (cipKey),
  .cipText   (cipText),
  .cipTweak  (cipTweak),
  .cipDone   (cipDone),
  .chainOut  (chainOut),
  .orderErr  (orderErr)
);

// File: tb/ubi_chain_top_tb.sv
module ubi_chain_top_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hashStart = 1'b0;
  logic [511:0] initChain = '0;
  logic         blkValid = 1'b0;
  logic         blkReady;
  logic [511:0] blkData = '0;
  logic [6:0]   blkBytes = '0;
  logic [5:0]   blkType = '0;
  logic         blkLast = 1'b0;
  logic         cipValid;
  logic [511:0] cipKey;
  logic [511:0] cipText;
  logic [127:0] cipTweak;
  logic         cipDone = 1'b0;
  logic [511:0] cipResult = '0;
  logic [511:0] chainOut;
  logic         orderErr;

  int nChecks = 0;
  int nErrors = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;

  // reference model state
  logic [511:0] mChain = '0;
  bit           mErr = 1'b0;
  bit           mInSeg = 1'b0;
  bit           mDrop = 1'b0;
  int           mLastType = -1;
  logic [95:0]  mPos = '0;
  logic [127:0] seenTwk;
  logic [511:0] seenText;

  always #2 clk = ~clk;

  ubi_chain_top u_dut (
    .clk(clk), .rstN(rstN), .hashStart(hashStart), .initChain(initChain),
    .blkValid(blkValid), .blkReady(blkReady), .blkData(blkData), .blkBytes(blkBytes),
    .blkType(blkType), .blkLast(blkLast), .cipValid(cipValid), .cipKey(cipKey),
    .cipText(cipText), .cipTweak(cipTweak), .cipDone(cipDone), .cipResult(cipResult),
    .chainOut(chainOut), .orderErr(orderErr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [511:0] padBlk(input logic [511:0] d, input int nb);
    logic [511:0] r = '0;
    for (int i = 0; i < 64; i++) if (i < nb) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  function automatic logic [511:0] stubCipher(input logic [511:0] k, input logic [511:0] t,
                                              input logic [127:0] w);
    return (k + {4{w}}) ^ {t[255:0], t[511:256]};
  endfunction

  function automatic logic [511:0] mkData(input int seed);
    logic [511:0] r;
    for (int j = 0; j < 16; j++) r[32*j +: 32] = 32'(seed) * 32'h9E3779B9 + 32'(j) * 32'h01010101;
    return r;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (monOn) begin
      chk(chainOut === mChain, "R5", "chain vs model", chainOut, mChain);
      chk(orderErr === mErr, "R11", "orderErr vs model", 512'(orderErr), 512'(mErr));
    end
  end

  task automatic seed(input logic [511:0] v);
    @(negedge clk);
    hashStart = 1'b1; initChain = v;
    @(posedge clk); #1;
    mChain = v; mErr = 0; mInSeg = 0; mDrop = 0; mLastType = -1; mPos = '0;
    @(negedge clk);
    hashStart = 1'b0;
    chk(chainOut == v, "R2", "seed loaded", chainOut, v);
    chk(!orderErr, "R2", "error cleared", 512'(orderErr), 512'(0));
  endtask

  task automatic sendBlk(input logic [5:0] typ, input int nb, input bit last,
                         input logic [511:0] data, input int lat);
    logic [511:0] pad;
    logic [127:0] twk;
    logic [511:0] res;
    bit first;
    bit dropIt;
    pad = padBlk(data, nb);
    first = !mInSeg;
    if (first) begin
      if (mLastType < 0 || int'(typ) > mLastType) begin
        dropIt = 0; mLastType = int'(typ); mPos = '0;
      end else dropIt = 1;
    end else dropIt = mDrop;
    if (!dropIt) mPos = mPos + 96'(nb);
    twk = {last, first, typ, 24'd0, mPos};

    @(negedge clk);
    blkValid = 1'b1; blkType = typ; blkBytes = 7'(nb); blkLast = last; blkData = data;
    chk(blkReady, "R3", "ready while idle", 512'(blkReady), 512'(1));
    @(posedge clk); #1;
    if (first && dropIt) mErr = 1;
    mInSeg = !last;
    mDrop = dropIt && !last;
    @(negedge clk);
    blkValid = 1'b0; blkData = '1; blkBytes = 7'd64; blkType = 6'd0; blkLast = 1'b0;
    if (dropIt) begin
      chk(!cipValid, "R11", "dropped block makes no request", 512'(cipValid), 512'(0));
      chk(blkReady, "R11", "ready after dropped block", 512'(blkReady), 512'(1));
    end else begin
      seenTwk = cipTweak; seenText = cipText;
      chk(cipValid, "R3", "request raised", 512'(cipValid), 512'(1));
      chk(!blkReady, "R3", "not ready while busy", 512'(blkReady), 512'(0));
      chk(cipKey == mChain, "R4", "key is chain", cipKey, mChain);
      chk(cipText == pad, "R9", "padded text", cipText, pad);
      chk(cipTweak[95:0] == twk[95:0], "R6", "position", 512'(cipTweak[95:0]), 512'(twk[95:0]));
      chk(cipTweak[125:96] == twk[125:96], "R7", "type and gap", 512'(cipTweak[125:96]), 512'(twk[125:96]));
      chk(cipTweak[127:126] == twk[127:126], "R8", "flags", 512'(cipTweak[127:126]), 512'(twk[127:126]));
      for (int c = 0; c < lat; c++) begin
        @(negedge clk);
        chk(cipValid && !blkReady, "R3", "request held", 512'(cipValid), 512'(1));
      end
      res = stubCipher(mChain, pad, twk);
      cipDone = 1'b1; cipResult = res;
      @(posedge clk); #1;
      mChain = res ^ pad;
      @(negedge clk);
      cipDone = 1'b0; cipResult = '0;
      chk(!cipValid, "R3", "request dropped after done", 512'(cipValid), 512'(0));
    end
  endtask

  initial begin
    logic [511:0] c1;
    logic [511:0] c2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk(chainOut == '0, "R1", "reset chain", chainOut, '0);
    chk(!orderErr, "R1", "reset error", 512'(orderErr), 512'(0));
    chk(!cipValid, "R1", "reset request", 512'(cipValid), 512'(0));
    chk(blkReady, "R1", "reset ready", 512'(blkReady), 512'(1));
    monOn = 1'b1;

    seed(mkData(1));
    // R9: short single-block configuration segment
    sendBlk(6'd4, 32, 1'b1, mkData(2), 0);
    // R6, R8: three-block message
    sendBlk(6'd48, 64, 1'b0, mkData(3), 2);
    sendBlk(6'd48, 64, 1'b0, mkData(4), 1);
    sendBlk(6'd48, 10, 1'b1, mkData(5), 3);
    // R10: empty output segment
    sendBlk(6'd63, 0, 1'b1, mkData(6), 1);
    chk(seenText == '0, "R10", "empty block text", seenText, '0);
    chk(seenTwk == {2'b11, 6'd63, 120'd0}, "R10", "empty block tweak", 512'(seenTwk),
        512'({2'b11, 6'd63, 120'd0}));

    // R11: out-of-order segment is dropped
    seed(mkData(7));
    sendBlk(6'd12, 64, 1'b1, mkData(8), 0);
    sendBlk(6'd8, 64, 1'b0, mkData(9), 0);
    sendBlk(6'd8, 5, 1'b1, mkData(10), 0);
    chk(orderErr, "R11", "error raised", 512'(orderErr), 512'(1));
    sendBlk(6'd20, 64, 1'b1, mkData(11), 1);
    chk(orderErr, "R11", "error sticky", 512'(orderErr), 512'(1));

    // R11: equal type is also rejected
    seed(mkData(12));
    sendBlk(6'd0, 64, 1'b1, mkData(13), 0);
    sendBlk(6'd0, 16, 1'b1, mkData(14), 0);
    chk(orderErr, "R11", "equal type rejected", 512'(orderErr), 512'(1));
    sendBlk(6'd16, 64, 1'b0, mkData(15), 0);
    sendBlk(6'd16, 64, 1'b1, mkData(16), 2);

    // R7: same data, different types, different chains
    seed(mkData(20));
    sendBlk(6'd48, 40, 1'b1, mkData(21), 0);
    c1 = chainOut;
    seed(mkData(20));
    sendBlk(6'd20, 40, 1'b1, mkData(21), 0);
    c2 = chainOut;
    chk(c1 != c2, "R7", "type separates chains", c2, c1);

    repeat (2) @(negedge clk);
    monOn = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule